// File: doc/BRIEF.md
# Template-Driven Instruction Bundle Expander

This block turns a compressed instruction bundle into a full-width issue packet. A bundle carries a small template number and a list of operation words. The template number selects a row of a programmable placement table. Each row says, for every operation position in the list, whether that position is used and which packet slot it lands in. The block writes every slot that the row does not name with the no-op word. Only the operations that the row names are consumed, so a short bundle costs no more than its own operations. The consumed count goes back upstream so that the fetch side can advance its pointer.

Bundles arrive on a valid/ready stream. Packets leave one cycle later from a registered valid/ready stage that holds its data steady under backpressure. The block flags two error conditions alongside the packet. The first is a template row with no mappings, which is the state every row has after reset. The second is a row that sends two operations to one slot. A simple write port loads the table one row per cycle.

Top module: `bundle_expander`

## Requirements
- R1: After synchronous active-low reset, `out_valid` is 0, `in_ready` is 1, and every template row holds no mappings.
- R2: For the selected row, operation i (bits `[i*OP_W +: OP_W]` of `in_ops`) appears in packet slot s (bits `[s*OP_W +: OP_W]` of `out_slots`) when the row marks i as used with slot index s. Every slot the row does not name carries `NOP_WORD`, which defaults to 0.
- R3: With a row mapping op 0 to slot 0, op 1 to slot 2 and op 2 to slot 5, the operations A,B,C expand to A,nop,B,nop,nop,C,nop,nop.
- R4: `in_used` is combinational and equals the number of used mappings in the row that `in_tid` selects.
- R5: A row with no used mapping gives an all-no-op packet with `out_err_tmpl` = 1, and `in_used` = 0.
- R6: When two used mappings in a row name the same slot, `out_err_conf` = 1 for that packet and the higher operation index fills the slot.
- R7: A bundle accepted at a rising edge (`in_valid` and `in_ready` both 1) appears on the outputs with `out_valid` = 1 right after that same edge.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and `out_slots`, `out_err_tmpl` and `out_err_conf` hold their values.
- R9: A table write loads row `cfg_addr` from `cfg_data`. For op i, field `[i*(SLOT_W+1) +: SLOT_W+1]` has its top bit as the used flag and its low SLOT_W bits as the slot index. A bundle accepted at the same edge as a write still sees the old row.
- R10: Operation words at positions that the row leaves unused have no effect on the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table row write strobe |
| cfg_addr | input | TID_W | Row to write |
| cfg_data | input | NUM_OPS*(SLOT_W+1) | Row contents: used flag and slot index per operation |
| in_valid | input | 1 | Bundle present |
| in_ready | output | 1 | Bundle accepted this cycle when valid |
| in_tid | input | TID_W | Template number of the bundle |
| in_ops | input | NUM_OPS*OP_W | Operation words, op 0 lowest |
| in_used | output | CNT_W | Operations the selected row consumes |
| out_valid | output | 1 | Packet present |
| out_ready | input | 1 | Downstream takes the packet |
| out_slots | output | NUM_SLOTS*OP_W | Expanded packet, slot 0 lowest |
| out_err_tmpl | output | 1 | Packet came from a row with no mappings |
| out_err_conf | output | 1 | Packet came from a row with a slot collision |

## Verification
On every cycle the assertions check that a stalled packet and its flags stay frozen, that an accepted bundle yields a valid packet on the next cycle, that a packet flagged for an empty row holds only no-ops, and that a collision flag comes only with at least two consumed operations. Only the bench's scenarios can show the actual placement of every operation for each programmed row, the later-index-wins rule, the insensitivity to unused operation words, and the old-row result for a bundle that meets a write at the same edge.

// File: rtl/bx_pkg.sv
// Package bx_pkg: default sizes shared by the bundle expander modules.
// Assumes every module picks these values as its parameter defaults.
package bx_pkg;
    parameter int DEF_TMPL  = 8;
    parameter int DEF_OPS   = 8;
    parameter int DEF_SLOTS = 8;
    parameter int DEF_OP_W  = 16;
endpackage

// File: rtl/bx_tmpl_table.sv
// bx_tmpl_table: register file of placement rows. Each row holds one
// (used flag, slot index) field per operation. Reads are combinational.
// Assumes one write per cycle and that reset clears every row.
module bx_tmpl_table #(
    parameter int NUM_TMPL = bx_pkg::DEF_TMPL,
    parameter int NUM_OPS  = bx_pkg::DEF_OPS,
    parameter int SLOT_W   = 3,
    localparam int TID_W   = (NUM_TMPL > 1) ? $clog2(NUM_TMPL) : 1,
    localparam int ROW_W   = NUM_OPS * (SLOT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [TID_W-1:0] wr_addr,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [TID_W-1:0] rd_addr,
    output logic [ROW_W-1:0] rd_row
);
    logic [ROW_W-1:0] rows [NUM_TMPL];

    // Clear all rows on reset; otherwise store the written row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TMPL; t++) rows[t] <= '0;
        end else if (wr_en) begin
            rows[wr_addr] <= wr_row;
        end
    end

    // Combinational row lookup for the bundle now on the input.
    always_comb rd_row = rows[rd_addr];
endmodule

// File: rtl/bx_slot_place.sv
// bx_slot_place: combinational placement network. It routes each used
// operation to its slot, fills the rest with the no-op word, counts the
// used mappings and detects two mappings that name the same slot.
// Assumes slot indices at or above NUM_SLOTS are simply dropped.
module bx_slot_place #(
    parameter int NUM_OPS   = bx_pkg::DEF_OPS,
    parameter int NUM_SLOTS = bx_pkg::DEF_SLOTS,
    parameter int OP_W      = bx_pkg::DEF_OP_W,
    parameter int SLOT_W    = 3,
    parameter logic [OP_W-1:0] NOP_WORD = '0,
    localparam int FW       = SLOT_W + 1,
    localparam int CNT_W    = $clog2(NUM_OPS + 1)
) (
    input  logic [NUM_OPS*FW-1:0]     row,
    input  logic [NUM_OPS*OP_W-1:0]   ops,
    output logic [NUM_SLOTS*OP_W-1:0] slots,
    output logic [CNT_W-1:0]          used,
    output logic                      empty,
    output logic                      conflict
);
    logic [NUM_OPS-1:0]   map_v;
    logic [SLOT_W-1:0]    map_s [NUM_OPS];
    logic [NUM_SLOTS-1:0] multi;

    // Split the row into per-operation used flags and slot indices.
    always_comb begin
        for (int i = 0; i < NUM_OPS; i++) begin
            map_v[i] = row[i*FW + SLOT_W];
            map_s[i] = row[i*FW +: SLOT_W];
        end
    end

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            logic [OP_W-1:0]  word;
            logic [CNT_W-1:0] hits;
            // Scan ops in rising order so the highest index wins the slot.
            always_comb begin
                word = NOP_WORD;
                hits = '0;
                for (int i = 0; i < NUM_OPS; i++) begin
                    if (map_v[i] && (map_s[i] == SLOT_W'(s))) begin
                        word = ops[i*OP_W +: OP_W];
                        hits = hits + 1'b1;
                    end
                end
            end
            assign slots[s*OP_W +: OP_W] = word;
            assign multi[s] = (hits > CNT_W'(1));
        end
    endgenerate

    // Count consumed operations and derive the two error conditions.
    always_comb begin
        used = '0;
        for (int i = 0; i < NUM_OPS; i++) used = used + CNT_W'(map_v[i]);
        empty    = (map_v == '0);
        conflict = |multi;
    end
endmodule

// File: rtl/bx_out_stage.sv
// bx_out_stage: single register stage with valid/ready flow control.
// Accepts new data when empty or when the current packet is taken.
// Assumes the upstream holds its data while in_ready is low.
module bx_out_stage #(
    parameter int DW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);
    logic take;

    // Ready whenever the stage is empty or is being drained.
    always_comb begin
        up_ready = !dn_valid || dn_ready;
        take     = up_valid && up_ready;
    end

    // Valid flag: set on a take, cleared when drained with nothing new.
    always_ff @(posedge clk) begin
        if (!rst_n)        dn_valid <= 1'b0;
        else if (take)     dn_valid <= 1'b1;
        else if (dn_ready) dn_valid <= 1'b0;
    end

    // Data register: loads only on a take, so it holds under a stall.
    always_ff @(posedge clk) begin
        if (!rst_n)    dn_data <= '0;
        else if (take) dn_data <= up_data;
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

    // R7
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready) |=> dn_valid);
endmodule

// File: rtl/bundle_expander.sv
// bundle_expander: expands a (template number, operation list) bundle
// into a full issue packet using a programmable placement table.
// Assumes cfg writes and bundles may coincide; a bundle then sees the
// row contents from before the write.
module bundle_expander #(
    parameter int NUM_TMPL  = bx_pkg::DEF_TMPL,
    parameter int NUM_OPS   = bx_pkg::DEF_OPS,
    parameter int NUM_SLOTS = bx_pkg::DEF_SLOTS,
    parameter int OP_W      = bx_pkg::DEF_OP_W,
    parameter logic [OP_W-1:0] NOP_WORD = '0,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int TID_W    = (NUM_TMPL > 1) ? $clog2(NUM_TMPL) : 1,
    localparam int ROW_W    = NUM_OPS * (SLOT_W + 1),
    localparam int CNT_W    = $clog2(NUM_OPS + 1),
    localparam int PKT_W    = NUM_SLOTS * OP_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [TID_W-1:0]        cfg_addr,
    input  logic [ROW_W-1:0]        cfg_data,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [TID_W-1:0]        in_tid,
    input  logic [NUM_OPS*OP_W-1:0] in_ops,
    output logic [CNT_W-1:0]        in_used,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [PKT_W-1:0]        out_slots,
    output logic                    out_err_tmpl,
    output logic                    out_err_conf
);
    logic [ROW_W-1:0] row;
    logic [PKT_W-1:0] placed;
    logic             empty;
    logic             conflict;
    logic [PKT_W+1:0] stage_out;

    bx_tmpl_table #(
        .NUM_TMPL (NUM_TMPL),
        .NUM_OPS  (NUM_OPS),
        .SLOT_W   (SLOT_W)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_row  (cfg_data),
        .rd_addr (in_tid),
        .rd_row  (row)
    );

    bx_slot_place #(
        .NUM_OPS   (NUM_OPS),
        .NUM_SLOTS (NUM_SLOTS),
        .OP_W      (OP_W),
        .SLOT_W    (SLOT_W),
        .NOP_WORD  (NOP_WORD)
    ) u_place (
        .row      (row),
        .ops      (in_ops),
        .slots    (placed),
        .used     (in_used),
        .empty    (empty),
        .conflict (conflict)
    );

    bx_out_stage #(
        .DW (PKT_W + 2)
    ) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  ({empty, conflict, placed}),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (stage_out)
    );

    // Unpack the registered packet and its two error flags.
    always_comb begin
        out_slots    = stage_out[PKT_W-1:0];
        out_err_conf = stage_out[PKT_W];
        out_err_tmpl = stage_out[PKT_W+1];
    end

    // R5
    empty_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err_tmpl) |-> (out_slots == {NUM_SLOTS{NOP_WORD}}));

    // R6
    conflict_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && conflict) |-> (in_used >= CNT_W'(2)));

    // R5
    empty_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && empty) |=> (out_err_tmpl && !out_err_conf));
endmodule

// File: tb/bundle_expander_bench.sv
`timescale 1ns/100ps
module bundle_expander_bench;
    localparam int NT = 8, NO = 8, NS = 8, OW = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_addr = '0;
    logic [31:0]  cfg_data = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [2:0]   in_tid = '0;
    logic [127:0] in_ops = '0;
    logic [3:0]   in_used;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_slots;
    logic         out_err_tmpl;
    logic         out_err_conf;

    int checks = 0;
    int errors = 0;

    // bench model of the placement table
    logic       mv [NT][NO];
    logic [2:0] ms [NT][NO];

    always #2.5 clk = ~clk;

    bundle_expander u_bundle_expander (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_tid(in_tid), .in_ops(in_ops), .in_used(in_used),
        .out_valid(out_valid), .out_ready(out_ready), .out_slots(out_slots),
        .out_err_tmpl(out_err_tmpl), .out_err_conf(out_err_conf)
    );

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_pkt(int t, logic [127:0] ops);
        logic [127:0] p = '0;
        for (int i = 0; i < NO; i++)
            if (mv[t][i]) p[ms[t][i]*OW +: OW] = ops[i*OW +: OW];
        return p;
    endfunction

    function automatic int exp_cnt(int t);
        int c = 0;
        for (int i = 0; i < NO; i++) if (mv[t][i]) c++;
        return c;
    endfunction

    function automatic logic exp_conf(int t);
        logic r = 1'b0;
        for (int i = 0; i < NO; i++)
            for (int j = i + 1; j < NO; j++)
                if (mv[t][i] && mv[t][j] && ms[t][i] == ms[t][j]) r = 1'b1;
        return r;
    endfunction

    function automatic logic [127:0] mk_ops(int t, int seed);
        logic [127:0] o;
        for (int i = 0; i < NO; i++) o[i*OW +: OW] = 16'h1000 + 16'(t*256 + seed*16 + i);
        return o;
    endfunction

    // write bench row t into the design (R9 field layout)
    task automatic prog(int t);
        logic [31:0] d = '0;
        for (int i = 0; i < NO; i++) d[i*4 +: 4] = {mv[t][i], ms[t][i]};
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(t); cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // send one bundle; check in_used before the edge, packet right after (R7)
    task automatic send(int t, logic [127:0] ops, logic [127:0] exp, string tag);
        in_valid = 1'b1; in_tid = 3'(t); in_ops = ops;
        #1;
        chk({tag, " R4 used"}, 128'(in_used), 128'(exp_cnt(t)));
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R7 valid"}, 128'(out_valid), 128'(1));
        chk({tag, " R2 pkt"}, out_slots, exp);
        chk({tag, " R5 err_tmpl"}, 128'(out_err_tmpl), 128'(exp_cnt(t) == 0));
        chk({tag, " R6 err_conf"}, 128'(out_err_conf), 128'(exp_conf(t)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] ab;
        for (int t = 0; t < NT; t++)
            for (int i = 0; i < NO; i++) begin mv[t][i] = 1'b0; ms[t][i] = '0; end

        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", 128'(out_valid), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", 128'(out_valid), 128'(0));
        chk("R1 in_ready after reset", 128'(in_ready), 128'(1));

        // R1 R5: every row empty after reset
        for (int t = 0; t < NT; t++) send(t, mk_ops(t, 1), '0, "R1 R5 empty row");

        // build rows: 0 = example, 1..6 = t+1 ops at (3i+t)%8, 7 = collision
        mv[0][0] = 1; ms[0][0] = 3'd0;
        mv[0][1] = 1; ms[0][1] = 3'd2;
        mv[0][2] = 1; ms[0][2] = 3'd5;
        for (int t = 1; t < 7; t++)
            for (int i = 0; i <= t; i++) begin mv[t][i] = 1; ms[t][i] = 3'((3*i + t) % 8); end
        mv[7][0] = 1; ms[7][0] = 3'd4;
        mv[7][1] = 1; ms[7][1] = 3'd4;
        mv[7][2] = 1; ms[7][2] = 3'd1;
        for (int t = 0; t < NT; t++) prog(t);

        // R3: A,B,C -> A,nop,B,nop,nop,C,nop,nop
        ab = '0;
        ab[0 +: 16] = 16'hAAAA; ab[16 +: 16] = 16'hBBBB; ab[32 +: 16] = 16'hCCCC;
        send(0, ab, {16'h0, 16'h0, 16'hCCCC, 16'h0, 16'h0, 16'hBBBB, 16'h0, 16'hAAAA}, "R3 example");

        // R2 R4 R6: sweep all rows with two operand patterns
        for (int t = 0; t < NT; t++)
            for (int p = 2; p < 4; p++) send(t, mk_ops(t, p), exp_pkt(t, mk_ops(t, p)), "R2 sweep");

        // R6: slot 4 holds op 1, not op 0
        send(7, mk_ops(7, 5), exp_pkt(7, mk_ops(7, 5)), "R6 collision");
        chk("R6 later index wins", 128'(out_slots[4*OW +: OW]), 128'(16'h1000 + 16'(7*256 + 5*16 + 1)));

        // R10: changing unused op words does not change the packet of row 1
        ab = mk_ops(1, 6);
        for (int i = 2; i < NO; i++) ab[i*OW +: OW] = 16'hDEAD;
        send(1, ab, exp_pkt(1, mk_ops(1, 6)), "R10 unused ops A");
        for (int i = 2; i < NO; i++) ab[i*OW +: OW] = 16'h5A5A;
        send(1, ab, exp_pkt(1, mk_ops(1, 6)), "R10 unused ops B");

        // R9: bundle meeting a write at the same edge sees the old row
        ab = exp_pkt(2, mk_ops(2, 7));
        in_valid = 1'b1; in_tid = 3'd2; in_ops = mk_ops(2, 7);
        cfg_we = 1'b1; cfg_addr = 3'd2; cfg_data = {28'h0, 4'b1111};
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        chk("R9 old row on write edge", out_slots, ab);
        for (int i = 0; i < NO; i++) mv[2][i] = 1'b0;
        mv[2][0] = 1; ms[2][0] = 3'd7;
        send(2, mk_ops(2, 8), exp_pkt(2, mk_ops(2, 8)), "R9 new row");
        chk("R9 op0 in slot 7", 128'(out_slots[7*OW +: OW]), 128'(16'h1000 + 16'(2*256 + 8*16)));

        // R5: row 7 rewritten to empty
        for (int i = 0; i < NO; i++) mv[7][i] = 1'b0;
        prog(7);
        send(7, mk_ops(7, 9), '0, "R5 cleared row");

        // R8: stall holds packet and blocks input
        @(negedge clk);
        out_ready = 1'b0;
        send(3, mk_ops(3, 10), exp_pkt(3, mk_ops(3, 10)), "R8 first");
        in_valid = 1'b1; in_tid = 3'd4; in_ops = mk_ops(4, 11);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8 held data", out_slots, exp_pkt(3, mk_ops(3, 10)));
            chk("R8 in_ready low", 128'(in_ready), 128'(0));
            chk("R8 valid held", 128'(out_valid), 128'(1));
        end
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 next packet after release", out_slots, exp_pkt(4, mk_ops(4, 11)));
        @(negedge clk);
        chk("R8 drained", 128'(out_valid), 128'(0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule